// File: doc/BRIEF.md
# Load-Byte Execution Sequencer

This block carries out one load-byte instruction over several clock cycles. An issue strobe supplies a destination register number, a base register number and a 16-bit signed offset. The block reads both registers, forms a 32-bit virtual address, and looks up the physical frame through a page-table port. It then fetches the whole aligned 32-bit word from the cache. The selected byte of that word replaces only the lowest byte of the destination register. The upper three bytes of that register are written back unchanged.

The surrounding core starts one instruction at a time and waits for the done pulse. The register file offers two combinational read ports and one write port. The page-table port answers in the cycle it is asked. The cache port accepts a request with a grant and returns data later with a valid strobe.

Top module: `ldbyte_engine`

## Requirements
- R1: Bits [31:8] of the written value equal bits [31:8] of the destination register as read in the cycle after issue.
- R2: Bits [7:0] of the written value are byte lane `a` of the fetched word, with `a` = physical address bits [1:0], little-endian: lane 0 is bits [7:0], lane 3 is bits [31:24].
- R3: The destination field drives both read port 1 select and the write select, so the register read is the register written.
- R4: The virtual address is base + sign-extended offset, modulo 2^32. During the single lookup cycle (`pt_lookup` high), `pt_vpn` carries address bits [31:14].
- R5: `cache_addr` is the 25-bit value {frame[10:0], virtual address bits [13:0]}. It is held steady with `cache_req` high until `cache_gnt` is seen.
- R6: Each accepted instruction produces exactly one single-cycle write, with `done` high in that cycle. With grant and data both returned at the first opportunity, the write occurs in the sixth cycle after the issue cycle.
- R7: An issue strobe while `busy` is high is ignored: no extra write happens and no register changes because of it.
- R8: After reset the block is idle: `busy`, `done`, `rf_we`, `cache_req` and `pt_lookup` are low.
- R9: `cache_rvalid` is taken only after the grant; data offered while the request is still waiting for its grant is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue strobe for one instruction |
| start_dst | input | 5 | Destination register number |
| start_base | input | 5 | Base register number |
| start_off | input | 16 | Signed address offset |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Pulse in the write-back cycle |
| rf_ra1 | output | 5 | Read port 1 select (destination) |
| rf_rd1 | input | 32 | Read port 1 data |
| rf_ra2 | output | 5 | Read port 2 select (base) |
| rf_rd2 | input | 32 | Read port 2 data |
| rf_wa | output | 5 | Write select |
| rf_wd | output | 32 | Write data |
| rf_we | output | 1 | Write enable |
| pt_lookup | output | 1 | Page-table lookup cycle |
| pt_vpn | output | 18 | Virtual page number |
| pt_frame | input | 11 | Frame number answered by the table |
| cache_req | output | 1 | Word read request |
| cache_addr | output | 25 | Physical byte address |
| cache_gnt | input | 1 | Request accepted |
| cache_rvalid | input | 1 | Read data valid |
| cache_rdata | input | 32 | Read data word |

## Verification
The hardest case to reach is a cache that holds off its grant while driving a spurious data-valid strobe with a poison word. Stimulus brings this about by programming the cache responder to delay the grant by several cycles and to assert valid with a marker pattern during that wait. Other cases are an issue strobe injected mid-sequence and a base register that is also the destination. Further cases are address wrap past 2^32 and negative offsets, and all four byte lanes at the same base address.

// File: rtl/ldb_pkg.sv
package ldb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_ADDR  = 3'd2,
        ST_XLATE = 3'd3,
        ST_CREQ  = 3'd4,
        ST_WAIT  = 3'd5,
        ST_WB    = 3'd6
    } ldb_state_e;

endpackage

// File: rtl/ldb_ctrl.sv
module ldb_ctrl
    import ldb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       cache_gnt,
    input  logic       cache_rvalid,
    output ldb_state_e state,
    output logic       accept,
    output logic       cap_regs,
    output logic       cap_va,
    output logic       cap_pa,
    output logic       cap_data,
    output logic       wb
);

    typedef struct packed {
        ldb_state_e st;
    } ctrl_s;

    ctrl_s ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        case (ctrl_q.st)
            ST_IDLE:  if (start) ctrl_d.st = ST_READ;
            ST_READ:  ctrl_d.st = ST_ADDR;
            ST_ADDR:  ctrl_d.st = ST_XLATE;
            ST_XLATE: ctrl_d.st = ST_CREQ;
            ST_CREQ:  if (cache_gnt) ctrl_d.st = ST_WAIT;
            ST_WAIT:  if (cache_rvalid) ctrl_d.st = ST_WB;
            ST_WB:    ctrl_d.st = ST_IDLE;
            default:  ctrl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '{st: ST_IDLE};
        else        ctrl_q <= ctrl_d;
    end

    assign state    = ctrl_q.st;
    assign accept   = (ctrl_q.st == ST_IDLE) && start;
    assign cap_regs = (ctrl_q.st == ST_READ);
    assign cap_va   = (ctrl_q.st == ST_ADDR);
    assign cap_pa   = (ctrl_q.st == ST_XLATE);
    assign cap_data = (ctrl_q.st == ST_WAIT) && cache_rvalid;
    assign wb       = (ctrl_q.st == ST_WB);

endmodule

// File: rtl/ldb_addr_gen.sv
module ldb_addr_gen #(
    parameter int VA_W      = 32,
    parameter int OFF_W     = 16,
    parameter int PAGE_BITS = 14,
    parameter int FRAME_W   = 11,
    localparam int VPN_W    = VA_W - PAGE_BITS,
    localparam int PA_W     = FRAME_W + PAGE_BITS
) (
    input  logic [VA_W-1:0]    base,
    input  logic [OFF_W-1:0]   off,
    input  logic [VA_W-1:0]    vmar,
    input  logic [FRAME_W-1:0] frame,
    output logic [VA_W-1:0]    va_sum,
    output logic [VPN_W-1:0]   vpn,
    output logic [PA_W-1:0]    pa
);

    logic [VA_W-1:0] off_ext;

    // replicate the sign bit across the upper part of the address width
    assign off_ext = {{(VA_W-OFF_W){off[OFF_W-1]}}, off};
    assign va_sum  = base + off_ext;
    assign vpn     = vmar[VA_W-1:PAGE_BITS];
    assign pa      = {frame, vmar[PAGE_BITS-1:0]};

endmodule

// File: rtl/ldb_byte_merge.sv
module ldb_byte_merge #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W,
    localparam int SEL_W = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] word,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] old,
    output logic [DATA_W-1:0] merged
);

    logic [LANE_W-1:0] lane [LANES];
    logic              unused_old_lo;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = word[g*LANE_W +: LANE_W];
    end

    // the low lane of the old value is replaced, so it is not consumed
    assign unused_old_lo = ^old[LANE_W-1:0];
    assign merged        = {old[DATA_W-1:LANE_W], lane[sel]};

endmodule

// File: rtl/ldbyte_engine.sv
module ldbyte_engine
    import ldb_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int VA_W      = 32,
    parameter int OFF_W     = 16,
    parameter int PAGE_BITS = 14,
    parameter int FRAME_W   = 11,
    parameter int RA_W      = 5,
    localparam int VPN_W    = VA_W - PAGE_BITS,
    localparam int PA_W     = FRAME_W + PAGE_BITS,
    localparam int SEL_W    = $clog2(DATA_W / 8)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [RA_W-1:0]    start_dst,
    input  logic [RA_W-1:0]    start_base,
    input  logic [OFF_W-1:0]   start_off,
    output logic               busy,
    output logic               done,
    output logic [RA_W-1:0]    rf_ra1,
    input  logic [DATA_W-1:0]  rf_rd1,
    output logic [RA_W-1:0]    rf_ra2,
    input  logic [DATA_W-1:0]  rf_rd2,
    output logic [RA_W-1:0]    rf_wa,
    output logic [DATA_W-1:0]  rf_wd,
    output logic               rf_we,
    output logic               pt_lookup,
    output logic [VPN_W-1:0]   pt_vpn,
    input  logic [FRAME_W-1:0] pt_frame,
    output logic               cache_req,
    output logic [PA_W-1:0]    cache_addr,
    input  logic               cache_gnt,
    input  logic               cache_rvalid,
    input  logic [DATA_W-1:0]  cache_rdata
);

    typedef struct packed {
        logic [RA_W-1:0]   dst;
        logic [RA_W-1:0]   base_reg;
        logic [OFF_W-1:0]  off;
        logic [DATA_W-1:0] tmp0;
        logic [VA_W-1:0]   basev;
        logic [VA_W-1:0]   vmar;
        logic [PA_W-1:0]   mar;
        logic [DATA_W-1:0] tmp1;
    } dp_s;

    dp_s dp_d, dp_q;

    ldb_state_e        state;
    logic              accept, cap_regs, cap_va, cap_pa, cap_data, wb;
    logic [VA_W-1:0]   va_sum;
    logic [PA_W-1:0]   pa;
    logic [DATA_W-1:0] merged;

    ldb_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .cache_gnt    (cache_gnt),
        .cache_rvalid (cache_rvalid),
        .state        (state),
        .accept       (accept),
        .cap_regs     (cap_regs),
        .cap_va       (cap_va),
        .cap_pa       (cap_pa),
        .cap_data     (cap_data),
        .wb           (wb)
    );

    ldb_addr_gen #(
        .VA_W      (VA_W),
        .OFF_W     (OFF_W),
        .PAGE_BITS (PAGE_BITS),
        .FRAME_W   (FRAME_W)
    ) u_addr (
        .base   (dp_q.basev),
        .off    (dp_q.off),
        .vmar   (dp_q.vmar),
        .frame  (pt_frame),
        .va_sum (va_sum),
        .vpn    (pt_vpn),
        .pa     (pa)
    );

    ldb_byte_merge #(
        .DATA_W (DATA_W),
        .LANE_W (8)
    ) u_merge (
        .word   (dp_q.tmp1),
        .sel    (dp_q.mar[SEL_W-1:0]),
        .old    (dp_q.tmp0),
        .merged (merged)
    );

    always_comb begin
        dp_d = dp_q;
        if (accept) begin
            dp_d.dst      = start_dst;
            dp_d.base_reg = start_base;
            dp_d.off      = start_off;
        end
        if (cap_regs) begin
            dp_d.tmp0  = rf_rd1;
            dp_d.basev = rf_rd2;
        end
        if (cap_va)   dp_d.vmar = va_sum;
        if (cap_pa)   dp_d.mar  = pa;
        if (cap_data) dp_d.tmp1 = cache_rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    // one register field selects both the old-value read and the write
    assign rf_ra1     = dp_q.dst;
    assign rf_wa      = dp_q.dst;
    assign rf_ra2     = dp_q.base_reg;
    assign rf_wd      = merged;
    assign rf_we      = wb;
    assign done       = wb;
    assign busy       = (state != ST_IDLE);
    assign pt_lookup  = cap_pa;
    assign cache_req  = (state == ST_CREQ);
    assign cache_addr = dp_q.mar;

endmodule

// File: rtl/ldbyte_engine_chk.sv
module ldbyte_engine_chk #(
    parameter int DATA_W    = 32,
    parameter int FRAME_W   = 11,
    parameter int PAGE_BITS = 14,
    parameter int RA_W      = 5,
    localparam int PA_W     = FRAME_W + PAGE_BITS,
    localparam int SEL_W    = $clog2(DATA_W / 8)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [RA_W-1:0]   rf_ra1,
    input logic [DATA_W-1:0] rf_rd1,
    input logic [RA_W-1:0]   rf_wa,
    input logic [DATA_W-1:0] rf_wd,
    input logic              rf_we,
    input logic              pt_lookup,
    input logic              cache_req,
    input logic [PA_W-1:0]   cache_addr,
    input logic              cache_gnt,
    input logic              cache_rvalid,
    input logic [DATA_W-1:0] cache_rdata
);

    logic              grab_old;
    logic              wait_data;
    logic [DATA_W-1:0] old_sh;
    logic [DATA_W-1:0] data_sh;
    logic [SEL_W-1:0]  sel_sh;
    logic [DATA_W-1:0] shifted;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grab_old  <= 1'b0;
            wait_data <= 1'b0;
            old_sh    <= '0;
            data_sh   <= '0;
            sel_sh    <= '0;
        end else begin
            grab_old <= start && !busy;
            if (grab_old) old_sh <= rf_rd1;
            if (cache_req && cache_gnt) begin
                wait_data <= 1'b1;
                sel_sh    <= cache_addr[SEL_W-1:0];
            end else if (wait_data && cache_rvalid) begin
                wait_data <= 1'b0;
                data_sh   <= cache_rdata;
            end
        end
    end

    assign shifted = data_sh >> {sel_sh, 3'b000};

    assert_upper_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> rf_wd[DATA_W-1:8] == old_sh[DATA_W-1:8]);

    assert_byte_pick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> rf_wd[7:0] == shifted[7:0]);

    assert_same_reg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> rf_wa == rf_ra1);

    assert_lookup_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pt_lookup |-> busy && !cache_req);

    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cache_req && !cache_gnt |=> cache_req && $stable(cache_addr));

    assert_done_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done == rf_we);

    assert_single_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we);

    assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> busy);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cache_req && !rf_we && !pt_lookup);

    assert_no_early_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cache_req |-> !wait_data);

endmodule

bind ldbyte_engine ldbyte_engine_chk #(
    .DATA_W    (DATA_W),
    .FRAME_W   (FRAME_W),
    .PAGE_BITS (PAGE_BITS),
    .RA_W      (RA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .busy         (busy),
    .done         (done),
    .rf_ra1       (rf_ra1),
    .rf_rd1       (rf_rd1),
    .rf_wa        (rf_wa),
    .rf_wd        (rf_wd),
    .rf_we        (rf_we),
    .pt_lookup    (pt_lookup),
    .cache_req    (cache_req),
    .cache_addr   (cache_addr),
    .cache_gnt    (cache_gnt),
    .cache_rvalid (cache_rvalid),
    .cache_rdata  (cache_rdata)
);

// File: tb/ldbyte_engine_test.sv
module ldbyte_engine_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  start_dst = '0, start_base = '0;
    logic [15:0] start_off = '0;
    logic        busy, done;
    logic [4:0]  rf_ra1, rf_ra2, rf_wa;
    logic [31:0] rf_rd1, rf_rd2, rf_wd;
    logic        rf_we, pt_lookup, cache_req;
    logic [17:0] pt_vpn;
    logic [10:0] pt_frame;
    logic [24:0] cache_addr;
    logic        cache_gnt = 1'b0, cache_rvalid = 1'b0;
    logic [31:0] cache_rdata = 32'hA5A5_A5A5;

    logic [31:0] regs [32];
    int checks = 0, fails = 0;
    bit finished = 0;

    typedef struct {
        logic [4:0]  dst;
        logic [31:0] wd;
        logic [24:0] pa;
        logic [17:0] vpn;
    } exp_t;
    exp_t exp_q[$];

    int  gw_cnt = 0, rd_lat = 0, lat_cnt = 0;
    bit  stray_en = 0, phase = 0, req_seen = 0;
    logic [24:0] lat_pa;

    always #4 clk = ~clk;

    ldbyte_engine uut (.*);

    function automatic logic [10:0] pt_fn(input logic [17:0] v);
        return v[10:0] ^ {v[17:11], 4'b1010};
    endfunction

    function automatic logic [31:0] mem_fn(input logic [24:0] a);
        logic [31:0] w;
        w = {7'b0, a[24:2], 2'b00};
        return w * 32'h9E37_79B1 + 32'h0F1E_2D3C;
    endfunction

    assign rf_rd1   = regs[rf_ra1];
    assign rf_rd2   = regs[rf_ra2];
    assign pt_frame = pt_fn(pt_vpn);

    always @(posedge clk) if (rf_we) regs[rf_wa] <= rf_wd;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // cache responder: grant after gw_cnt waits, data after rd_lat more cycles
    initial forever begin
        @(negedge clk);
        cache_gnt = 1'b0;
        cache_rvalid = 1'b0;
        cache_rdata = 32'hA5A5_A5A5;
        if (phase) begin
            if (lat_cnt == 0) begin
                cache_rvalid = 1'b1;
                cache_rdata = mem_fn(lat_pa);
                phase = 0;
            end else lat_cnt--;
        end else if (cache_req) begin
            if (gw_cnt == 0) begin
                cache_gnt = 1'b1;
                phase = 1;
                lat_pa = cache_addr;
                lat_cnt = rd_lat;
            end else begin
                gw_cnt--;
                if (stray_en) begin
                    cache_rvalid = 1'b1;
                    cache_rdata = 32'hDEAD_BEEF;
                end
            end
        end
    end

    // monitor: pop expected results as the design produces them
    always @(negedge clk) begin
        if (rst_n) begin
            if (pt_lookup && exp_q.size() > 0)
                chk(pt_vpn == exp_q[0].vpn, "R4 page number", 32'(pt_vpn), 32'(exp_q[0].vpn));
            if (cache_req && !req_seen && exp_q.size() > 0) begin
                req_seen = 1;
                chk(cache_addr == exp_q[0].pa, "R5 physical address", 32'(cache_addr), 32'(exp_q[0].pa));
            end
            if (rf_we) begin
                req_seen = 0;
                if (exp_q.size() == 0) chk(0, "R7 unexpected write", 32'(rf_wa), 32'h0);
                else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(rf_wa == e.dst && rf_ra1 == e.dst, "R3 register select", 32'(rf_wa), 32'(e.dst));
                    chk(rf_wd[31:8] == e.wd[31:8], "R1 upper bytes", rf_wd, e.wd);
                    chk(rf_wd[7:0] == e.wd[7:0], "R2 byte lane", rf_wd, e.wd);
                    chk(done, "R6 done with write", 32'(done), 32'h1);
                end
            end
        end
    end

    task automatic issue(input logic [4:0] dst, input logic [4:0] base, input logic [15:0] off,
                         input int gw, input int lat, input bit stray, input bit poke, output int cyc);
        exp_t e;
        logic [31:0] va, w;
        logic [7:0]  b;
        va = regs[base] + {{16{off[15]}}, off};
        e.vpn = va[31:14];
        e.pa  = {pt_fn(e.vpn), va[13:0]};
        w = mem_fn(e.pa);
        b = w[e.pa[1:0]*8 +: 8];
        e.wd  = {regs[dst][31:8], b};
        e.dst = dst;
        exp_q.push_back(e);
        gw_cnt = gw; rd_lat = lat; stray_en = stray;
        start = 1'b1; start_dst = dst; start_base = base; start_off = off;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!rf_we && cyc < 200) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 3) begin
                start = 1'b1; start_dst = 5'd20; start_base = 5'd1; start_off = 16'h0040;
            end else start = 1'b0;
        end
        start = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int cyc;
        logic [31:0] keep20;
        for (int i = 0; i < 32; i++) regs[i] = (i * 32'h0101_0101) ^ 32'hC0FF_EE00;
        regs[5]  = 32'h0012_3458;
        regs[7]  = 32'h0001_0000;
        regs[10] = 32'hFFFF_FFFE;
        repeat (3) @(negedge clk);
        // R8 reset state
        chk(!busy, "R8 busy low", 32'(busy), 0);
        chk(!done, "R8 done low", 32'(done), 0);
        chk(!rf_we, "R8 write low", 32'(rf_we), 0);
        chk(!cache_req, "R8 request low", 32'(cache_req), 0);
        chk(!pt_lookup, "R8 lookup low", 32'(pt_lookup), 0);
        rst_n = 1'b1;
        @(negedge clk);

        issue(5'd3, 5'd5, 16'd2, 0, 0, 0, 0, cyc);
        chk(cyc == 6, "R6 minimum latency", 32'(cyc), 6);
        for (int k = 0; k < 4; k++) issue(5'd9, 5'd7, 16'(k), 0, 1, 0, 0, cyc);   // R2 all lanes
        issue(5'd11, 5'd7, 16'hFFFC, 1, 0, 0, 0, cyc);                           // R4 negative offset
        issue(5'd13, 5'd10, 16'd5, 0, 0, 0, 0, cyc);                             // R4 wrap
        issue(5'd12, 5'd12, 16'd4, 0, 2, 0, 0, cyc);                             // R3 base is destination
        issue(5'd14, 5'd5, 16'h0101, 3, 2, 1, 0, cyc);                           // R9 stray data, R5 hold
        chk(cyc == 11, "R9 latency with delayed grant", 32'(cyc), 11);
        keep20 = regs[20];
        issue(5'd15, 5'd7, 16'h7FFF, 2, 1, 0, 1, cyc);                           // R7 issue while busy
        repeat (10) @(negedge clk);
        chk(!busy, "R7 idle after ignored issue", 32'(busy), 0);
        chk(regs[20] == keep20, "R7 register untouched", regs[20], keep20);
        for (int n = 0; n < 24; n++)
            issue(5'(n * 7 + 1), 5'(n * 3 + 2), 16'(n * 16'h1235), n % 3, n % 4, n[0], 0, cyc);
        chk(exp_q.size() == 0, "R6 one write per instruction", 32'(exp_q.size()), 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule